// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running up-counter with a programmable prescaler and a set of compare channels, reached through a small word-addressed register bus. A prescale counter advances on every enabled clock; when it reaches the prescale limit it returns to zero and the main counter steps by one. Each compare channel watches the main counter. On a match it can latch an interrupt flag, make the counter return to zero at its next step, or stop the counter by clearing the run bit.

Software configures the limit, the compare values and the per-channel actions. It can then use the block as a free-running time base or as a one-shot event source. In one-shot use, a compare value of 1 is set with all three actions, and the wanted delay is loaded into the prescale limit. A single level interrupt output is the OR of all flags.

Top module: `ptmr_top`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `bus_ready` is low.
- R2: `bus_ready` rises in the cycle after `bus_sel` is first seen and stays high for one cycle only. A transfer completes at the clock edge where both are high, and `bus_rdata` is valid while `bus_ready` is high. Byte offsets are: flags 0x00, control 0x04, counter 0x08, prescale limit 0x0C, prescale counter 0x10, action control 0x14, compare value n at 0x18+4n, count control 0x70. Other offsets read zero, and writes to them are ignored.
- R3: Control bit 0 is the run bit. While it is clear, neither counter changes.
- R4: While control bit 1 is set, the counter and the prescale counter are held at zero, whatever the run bit says.
- R5: On each running clock, the prescale counter increments. When it is equal to or above the 32-bit prescale limit, it returns to zero and the counter steps by one. A limit of 0 therefore steps the counter on every clock.
- R6: The 32-bit counter wraps from 0xFFFFFFFF to 0.
- R7: The action control register holds three bits per channel n: bit 3n is interrupt, bit 3n+1 is reset, bit 3n+2 is stop. Its other bits read zero. Flag bit n is set when the counter steps to compare value n while the interrupt bit of channel n is set. Compares are made only on steps, so a flag cleared while the counter still holds that value does not return.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R9: `irq` is high exactly when any flag bit is set.
- R10: With reset enabled on channel n, when the counter holds compare value n, its next step goes to 0 instead of the value plus one.
- R11: With stop enabled on channel n, the step that reaches compare value n clears the run bit in the same edge. A bus write to control in that same cycle takes priority.
- R12: The counter and the prescale counter can be written over the bus, and reads return their live values.
- R13: The count control register reads back the low 4 bits written to it and has no effect on counting.
- R14: With compare value 0 set to 1, all three channel-0 actions set and a prescale limit D, flag 0 sets D+1 clocks after the run bit is set. The block then stops with the counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Transfer request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Transfer completes at this edge |
| irq | output | 1 | Level interrupt, OR of the flags |

## Verification
A compare channel can set its flag in the same edge as a software write-one clear of that flag. A stop-on-match can also clear the run bit in the same edge as a software write to the control register. The bench starts the counter with a prescale limit of 0, so the counter value is known on every clock. It then times a clear of the flag, and separately a control write, to commit exactly on the step that reaches the compare value. The flag must read back set, and the run bit must still read one while the counter keeps advancing.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   // byte offsets within the register window
   localparam int OFS_FLAG  = 'h00;
   localparam int OFS_CTRL  = 'h04;
   localparam int OFS_CNT   = 'h08;
   localparam int OFS_LIM   = 'h0C;
   localparam int OFS_PCNT  = 'h10;
   localparam int OFS_ACT   = 'h14;
   localparam int OFS_CMP   = 'h18;
   localparam int OFS_CCTL  = 'h70;
   // per-channel action bit positions inside a 3-bit group
   localparam int ACT_INT   = 0;
   localparam int ACT_RST   = 1;
   localparam int ACT_STOP  = 2;
   localparam int ACT_BITS  = 3;
   // control bit positions
   localparam int CTL_RUN   = 0;
   localparam int CTL_HOLD  = 1;
   localparam int CTL_W     = 2;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] pcnt,
   output logic             tick
);
   logic at_lim;
   assign at_lim = (pcnt >= limit);
   assign tick   = run & ~hold & ~wr & at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pcnt <= '0;
      else if (hold)          pcnt <= '0;
      else if (wr)            pcnt <= wdata;
      else if (run) begin
         if (at_lim)          pcnt <= '0;
         else                 pcnt <= pcnt + CNT_W'(1);
      end
   end

   // R5: below the limit a running clock advances the prescale counter by one
   a_r5_prescale_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !hold && !wr && (pcnt < limit)) |=> (pcnt == $past(pcnt) + CNT_W'(1)));

   // R4: hold forces zero on the next edge
   a_r4_pcnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (pcnt == '0));
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             rst_any,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] nxt
);
   assign nxt = rst_any ? '0 : cnt + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (hold)     cnt <= '0;
      else if (wr)       cnt <= wdata;
      else if (tick)     cnt <= nxt;
   end

   // R5 / R6: a plain step adds one, wrapping at the top
   a_r5_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hold && !wr && !rst_any) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R3: no step, no write, no hold -> counter does not move
   a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !hold && !wr) |=> $stable(cnt));

   // R4: hold zeroes the counter
   a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cnt == '0));
endmodule

// File: rtl/ptmr_chan.sv
module ptmr_chan
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [CNT_W-1:0]    wdata,
   input  logic [CNT_W-1:0]    cnt,
   input  logic [CNT_W-1:0]    nxt,
   input  logic                tick,
   input  logic [ACT_BITS-1:0] act,
   output logic [CNT_W-1:0]    cmp,
   output logic                hit_int,
   output logic                hit_rst,
   output logic                hit_stop
);
   logic reach;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cmp <= '0;
      else if (wr) cmp <= wdata;
   end

   assign reach    = tick & (nxt == cmp);
   assign hit_int  = reach & act[ACT_INT];
   assign hit_stop = reach & act[ACT_STOP];
   assign hit_rst  = act[ACT_RST] & (cnt == cmp);

   // R7: no compare event without a counter step
   a_r7_step_only: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> !(hit_int || hit_stop));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8,
   parameter int CCTL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              bus_ready,
   output logic              irq
);
   localparam int ACT_W = NUM_CH * ACT_BITS;

   initial begin
      assert (ACT_W <= CNT_W) else $error("action field wider than data bus");
      assert (NUM_CH >= 1 && OFS_CMP + 4 * NUM_CH <= OFS_CCTL)
         else $error("compare window overlaps count control");
      assert (ADDR_W >= 7) else $error("address too narrow for register window");
      assert (CCTL_W >= 1 && CCTL_W <= CNT_W) else $error("bad count control width");
   end

   logic              ready_q, acc, wr;
   logic [CTL_W-1:0]  ctrl_q;
   logic [CNT_W-1:0]  lim_q;
   logic [ACT_W-1:0]  act_q;
   logic [CCTL_W-1:0] cctl_q;
   logic [NUM_CH-1:0] flag_q;
   logic [CNT_W-1:0]  cnt, nxt, pcnt;
   logic              pre_tick, step;
   logic [NUM_CH-1:0] hit_int, hit_rst, hit_stop, cmp_wr;
   logic [CNT_W-1:0]  cmp [NUM_CH];

   // ---------------- bus handshake ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= bus_sel & ~ready_q;
   end
   assign bus_ready = ready_q;
   assign acc       = bus_sel & ready_q;
   assign wr        = acc & bus_write;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic wr_flag, wr_ctrl, wr_cnt, wr_lim, wr_pcnt, wr_act, wr_cctl;
   assign wr_flag = wr & at(bus_addr, OFS_FLAG);
   assign wr_ctrl = wr & at(bus_addr, OFS_CTRL);
   assign wr_cnt  = wr & at(bus_addr, OFS_CNT);
   assign wr_lim  = wr & at(bus_addr, OFS_LIM);
   assign wr_pcnt = wr & at(bus_addr, OFS_PCNT);
   assign wr_act  = wr & at(bus_addr, OFS_ACT);
   assign wr_cctl = wr & at(bus_addr, OFS_CCTL);

   // ---------------- configuration registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q  <= '0;
         act_q  <= '0;
         cctl_q <= '0;
      end else begin
         if (wr_lim)  lim_q  <= bus_wdata;
         if (wr_act)  act_q  <= bus_wdata[ACT_W-1:0];
         if (wr_cctl) cctl_q <= bus_wdata[CCTL_W-1:0];
      end
   end

   // control: software write beats stop-on-match
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ctrl_q <= '0;
      else if (wr_ctrl)       ctrl_q <= bus_wdata[CTL_W-1:0];
      else if (|hit_stop)     ctrl_q[CTL_RUN] <= 1'b0;
   end

   // flags: new events beat write-one clears
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~(wr_flag ? bus_wdata[NUM_CH-1:0] : '0)) | hit_int;
   end
   assign irq = |flag_q;

   // ---------------- datapath ----------------
   ptmr_prescale #(.CNT_W(CNT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q[CTL_RUN]), .hold(ctrl_q[CTL_HOLD]),
      .wr(wr_pcnt), .wdata(bus_wdata), .limit(lim_q), .pcnt(pcnt), .tick(pre_tick));

   assign step = pre_tick & ~wr_cnt;

   ptmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(step), .hold(ctrl_q[CTL_HOLD]),
      .wr(wr_cnt), .wdata(bus_wdata), .rst_any(|hit_rst), .cnt(cnt), .nxt(nxt));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      assign cmp_wr[n] = wr & at(bus_addr, OFS_CMP + 4 * n);
      ptmr_chan #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .wr(cmp_wr[n]), .wdata(bus_wdata),
         .cnt(cnt), .nxt(nxt), .tick(step),
         .act(act_q[ACT_BITS*n +: ACT_BITS]), .cmp(cmp[n]),
         .hit_int(hit_int[n]), .hit_rst(hit_rst[n]), .hit_stop(hit_stop[n]));
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (acc) begin
         if (at(bus_addr, OFS_FLAG)) bus_rdata = CNT_W'(flag_q);
         if (at(bus_addr, OFS_CTRL)) bus_rdata = CNT_W'(ctrl_q);
         if (at(bus_addr, OFS_CNT))  bus_rdata = cnt;
         if (at(bus_addr, OFS_LIM))  bus_rdata = lim_q;
         if (at(bus_addr, OFS_PCNT)) bus_rdata = pcnt;
         if (at(bus_addr, OFS_ACT))  bus_rdata = CNT_W'(act_q);
         if (at(bus_addr, OFS_CCTL)) bus_rdata = CNT_W'(cctl_q);
         for (int n = 0; n < NUM_CH; n++)
            if (at(bus_addr, OFS_CMP + 4 * n)) bus_rdata = cmp[n];
      end
   end

   // R2: ready is a single-cycle pulse
   a_r2_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);

   // R8: without a clear write no flag ever falls
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> (($past(flag_q) & ~flag_q) == '0));

   // R11: a stop event with no competing control write clears the run bit
   a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((|hit_stop) && !wr_ctrl) |=> !ctrl_q[CTL_RUN]);

   // R9: a flag event raises the interrupt on the following cycle
   a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_int) |=> irq);
endmodule

// File: tb/test_ptmr_top.sv
`timescale 1ns/1ps
module test_ptmr_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ptmr_top i_ptmr_top (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .irq(irq));

   localparam logic [7:0] A_FLAG = 8'h00, A_CTRL = 8'h04, A_CNT = 8'h08, A_LIM = 8'h0C,
                          A_PCNT = 8'h10, A_ACT = 8'h14, A_CMP0 = 8'h18, A_CMP1 = 8'h1C,
                          A_CMP2 = 8'h20, A_CMP3 = 8'h24, A_CCTL = 8'h70;

   typedef struct packed {
      logic        wr;
      logic [7:0]  a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h0C, 32'h1234_5678, 32'h0},          // R5 limit is 32 bits
      '{1'b0, 8'h0C, 32'h0,         32'h1234_5678},
      '{1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},          // R7 only 12 action bits
      '{1'b0, 8'h14, 32'h0,         32'h0000_0FFF},
      '{1'b1, 8'h18, 32'hA5A5_0001, 32'h0},          // R2 compare offsets
      '{1'b1, 8'h24, 32'h0000_0077, 32'h0},
      '{1'b0, 8'h18, 32'h0,         32'hA5A5_0001},
      '{1'b0, 8'h24, 32'h0,         32'h0000_0077},
      '{1'b1, 8'h70, 32'hFFFF_FFF9, 32'h0},          // R13 low 4 bits kept
      '{1'b0, 8'h70, 32'h0,         32'h0000_0009},
      '{1'b1, 8'h40, 32'hDEAD_BEEF, 32'h0},          // R2 unmapped
      '{1'b0, 8'h40, 32'h0,         32'h0},
      '{1'b0, 8'h08, 32'h0,         32'h0},          // R13 counter untouched
      '{1'b1, 8'h14, 32'h0,         32'h0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at a falling edge two cycles later
   task automatic bus_op(input logic w, input logic [7:0] a, input logic [31:0] d,
                         output logic [31:0] q);
      bus_sel = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      if (bus_ready !== 1'b1) begin
         n_chk++; n_bad++;
         $display("FAIL R2: ready got %b expected 1", bus_ready);
      end
      q = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_write = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] q;
      bus_op(1'b1, a, d, q);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] q;
      bus_op(1'b0, a, 32'h0, q);
      chk(tag, q, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 ready", {31'b0, bus_ready}, 32'h0);
      // R2 ready timing, watched by hand
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = A_CTRL;
      #1 chk("R2 ready low first cycle", {31'b0, bus_ready}, 32'h0);
      @(posedge clk); @(negedge clk);
      chk("R2 ready high second cycle", {31'b0, bus_ready}, 32'h1);
      chk("R1 control", bus_rdata, 32'h0);
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0;
      chk("R2 ready single pulse", {31'b0, bus_ready}, 32'h0);
      rd_chk("R1 flags", A_FLAG, 32'h0);
      rd_chk("R1 counter", A_CNT, 32'h0);
      rd_chk("R1 prescale counter", A_PCNT, 32'h0);

      // table of register vectors (R2, R5, R7, R13)
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
         else rd_chk($sformatf("R2 table entry %0d", i), VEC[i].a, VEC[i].e);
      end

      // R5 limit 0 steps every clock; R3 stop on run clear
      wr(A_CTRL, 32'h2); wr(A_LIM, 32'h0); wr(A_CTRL, 32'h1);
      rd_chk("R5 limit0 first", A_CNT, 32'd1);
      rd_chk("R5 limit0 third", A_CNT, 32'd3);
      wr(A_CTRL, 32'h0);
      rd_chk("R3 halted", A_CNT, 32'd6);
      rd_chk("R3 still halted", A_CNT, 32'd6);

      // R5 limit 2; R4 hold
      wr(A_CTRL, 32'h2); wr(A_LIM, 32'h2); wr(A_CTRL, 32'h1);
      rd_chk("R5 pcnt after 1", A_PCNT, 32'd1);
      rd_chk("R5 cnt after 3", A_CNT, 32'd1);
      rd_chk("R5 pcnt after 5", A_PCNT, 32'd2);
      wr(A_CTRL, 32'h3);
      rd_chk("R4 cnt held", A_CNT, 32'd0);
      rd_chk("R4 pcnt held", A_PCNT, 32'd0);

      // R6 wrap
      wr(A_CTRL, 32'h0); wr(A_LIM, 32'h0); wr(A_CNT, 32'hFFFF_FFFE); wr(A_CTRL, 32'h1);
      rd_chk("R6 top", A_CNT, 32'hFFFF_FFFF);
      rd_chk("R6 wrapped", A_CNT, 32'd1);

      // R12 direct writes
      wr(A_CTRL, 32'h0); wr(A_LIM, 32'd10); wr(A_CNT, 32'd100); wr(A_PCNT, 32'd7);
      wr(A_CTRL, 32'h1);
      rd_chk("R12 pcnt live", A_PCNT, 32'd8);
      rd_chk("R12 cnt before step", A_CNT, 32'd100);
      rd_chk("R12 cnt after step", A_CNT, 32'd101);

      // R7 / R9 / R8 interrupt on channel 2
      wr(A_CTRL, 32'h2); wr(A_FLAG, 32'hF); wr(A_LIM, 32'h0); wr(A_CMP2, 32'd5);
      wr(A_ACT, 32'h40); wr(A_CTRL, 32'h1);
      rd_chk("R7 no flag yet", A_FLAG, 32'h0);
      chk("R9 irq low", {31'b0, irq}, 32'h0);
      idle(8);
      rd_chk("R7 flag ch2", A_FLAG, 32'h4);
      chk("R9 irq high", {31'b0, irq}, 32'h1);
      wr(A_FLAG, 32'h0);
      rd_chk("R8 write 0 no effect", A_FLAG, 32'h4);
      wr(A_FLAG, 32'h4);
      rd_chk("R8 write 1 clears", A_FLAG, 32'h0);
      chk("R9 irq low after clear", {31'b0, irq}, 32'h0);

      // R7 one event per counter value
      wr(A_CTRL, 32'h2); wr(A_LIM, 32'd20); wr(A_CMP1, 32'd1); wr(A_ACT, 32'h08);
      wr(A_CTRL, 32'h1);
      idle(25);
      rd_chk("R7 flag ch1", A_FLAG, 32'h2);
      wr(A_FLAG, 32'h2);
      rd_chk("R7 no refire on same value", A_FLAG, 32'h0);
      rd_chk("R7 counter still at match", A_CNT, 32'd1);

      // R10 reset on match
      wr(A_CTRL, 32'h2); wr(A_LIM, 32'h0); wr(A_CMP0, 32'd3); wr(A_ACT, 32'h2);
      wr(A_CTRL, 32'h1);
      rd_chk("R10 step 1", A_CNT, 32'd1);
      rd_chk("R10 reaches match", A_CNT, 32'd3);
      rd_chk("R10 restarted", A_CNT, 32'd1);

      // R14 one-shot event, R11 stop
      wr(A_CTRL, 32'h2); wr(A_FLAG, 32'hF); wr(A_LIM, 32'd4); wr(A_CMP0, 32'd1);
      wr(A_ACT, 32'h7); wr(A_CTRL, 32'h1);
      rd_chk("R14 no flag at 1", A_FLAG, 32'h0);
      rd_chk("R14 no flag at 3", A_FLAG, 32'h0);
      rd_chk("R14 flag at D+1", A_FLAG, 32'h1);
      chk("R14 irq", {31'b0, irq}, 32'h1);
      rd_chk("R11 run cleared", A_CTRL, 32'h0);
      rd_chk("R14 halted at 1", A_CNT, 32'd1);

      // R8 set and clear in one edge: set wins
      wr(A_CTRL, 32'h2); wr(A_FLAG, 32'hF); wr(A_LIM, 32'h0); wr(A_CMP3, 32'd2);
      wr(A_ACT, 32'h200); wr(A_CTRL, 32'h1);
      wr(A_FLAG, 32'h8);
      rd_chk("R8 set beats clear", A_FLAG, 32'h8);
      wr(A_FLAG, 32'h8);

      // R11 control write beats stop in one edge
      wr(A_CTRL, 32'h2); wr(A_LIM, 32'h0); wr(A_CMP0, 32'd2); wr(A_ACT, 32'h4);
      wr(A_CTRL, 32'h1);
      wr(A_CTRL, 32'h1);
      rd_chk("R11 write wins", A_CTRL, 32'h1);
      rd_chk("R11 still counting", A_CNT, 32'd5);
      wr(A_CTRL, 32'h0);

      finish_run();
   end
endmodule